// File: doc/BRIEF.md
# SPI DMA Request and Interrupt Gating

This block sits beside the transmit and receive FIFOs of an SPI core and decides when a DMA controller is asked to move data. It keeps the fill count of both eight-entry FIFOs from their write and read strobes. It raises a transmit request whenever the transmit FIFO has room, and a receive request whenever the receive FIFO holds data. Both requests are gated by one global DMA enable and by a separate enable for each direction, so either direction or both can be served at once.

The same block produces the SPI interrupt flags. The ordinary "transmit FIFO drained" and "byte received" events are reported only while DMA is off. Transmit underrun and receive overflow are always reported. Clearing the DMA enable stops the requests but leaves the serial engine free to drain bytes already queued for transmission. The fill counts are visible so software can see how much is still waiting.

Top module: `spi_dma_gate`

## Requirements
- R1: While `dma_en` is 0, neither `tx_req` nor `rx_req` is asserted.
- R2: `tx_req` depends only on `tx_dma_en` among the direction enables, and `rx_req` depends only on `rx_dma_en`; the two may be active together.
- R3: With `dma_en` and `tx_dma_en` both 1, `tx_req` is 1 whenever `tx_level` is below 8. With `dma_en` and `rx_dma_en` both 1, `rx_req` is 1 whenever `rx_level` is above 0. This holds unless R4 forces the request low.
- R4: In the cycle after an edge at which `tx_ack` (or `rx_ack`) was 1, `tx_req` (or `rx_req`) is 0. The request may reassert one cycle later.
- R5: Each level is a 4-bit count from 0 to 8. A write strobe increments it unless the FIFO is full, and a read strobe decrements it unless the FIFO is empty.
- R6: `tx_rd` at `tx_level` 0 sets the underrun flag (`flags[2]`) whatever `dma_en` is, and the level stays 0.
- R7: With `rx_flush` at 0, `rx_wr` at `rx_level` 8 sets the overflow flag (`flags[3]`), and the byte is dropped, so the level stays 8. With `rx_flush` at 1, `rx_level` goes to 0 and `rx_wr` is ignored without setting the overflow flag.
- R8: The transmit flag (`flags[0]`) sets when a read empties the transmit FIFO. The receive flag (`flags[1]`) sets when a byte enters the receive FIFO. Both events set their flag only while `dma_en` is 0.
- R9: `tx_rd` drains the transmit FIFO regardless of `dma_en`, so bytes queued before DMA is turned off are still sent.
- R10: Flags are sticky until the matching `flag_clr` bit is pulsed (bit 0 transmit, 1 receive, 2 underrun, 3 overflow). `irq` is the OR of the four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Global DMA enable |
| tx_dma_en | input | 1 | Transmit request enable |
| rx_dma_en | input | 1 | Receive request enable |
| rx_flush | input | 1 | Hold receive FIFO empty, discard incoming bytes |
| tx_wr | input | 1 | Byte written into transmit FIFO |
| tx_rd | input | 1 | Serial engine takes a byte from transmit FIFO |
| rx_wr | input | 1 | Serial engine delivers a received byte |
| rx_rd | input | 1 | Byte read from receive FIFO |
| tx_ack | input | 1 | DMA acknowledge of transmit request |
| rx_ack | input | 1 | DMA acknowledge of receive request |
| flag_clr | input | 4 | Per-flag clear pulses |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_level | output | 4 | Transmit FIFO fill count |
| rx_level | output | 4 | Receive FIFO fill count |
| flags | output | 4 | Sticky flags: transmit, receive, underrun, overflow |
| irq | output | 1 | Interrupt, OR of flags |

## Verification
On every cycle the assertions check that no request appears without the global enable, that an acknowledge is followed by a dropped request, and that the counts stay within 0 to 8. They also check that underrun and overflow events are flagged on the next edge and that the ordinary flags never rise while DMA was on. The bench sweeps every combination of the three enables against every pair of fill levels. Only its scenarios can show three things: the transmit FIFO draining after DMA is stopped, the flush discarding bytes, and the flags clearing one by one.

// File: rtl/spi_dma_gate.sv
module spi_dma_gate #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          tx_dma_en,
  input  logic          rx_dma_en,
  input  logic          rx_flush,
  input  logic          tx_wr,
  input  logic          tx_rd,
  input  logic          rx_wr,
  input  logic          rx_rd,
  input  logic          tx_ack,
  input  logic          rx_ack,
  input  logic [3:0]    flag_clr,
  output logic          tx_req,
  output logic          rx_req,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic [3:0]    flags,
  output logic          irq
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] ONE  = LW'(1);

  logic [LW-1:0] tx_cnt, rx_cnt;
  logic          tx_hold, rx_hold;
  logic [3:0]    flg;

  wire tx_full  = (tx_cnt == FULL);
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL);
  wire rx_empty = (rx_cnt == '0);

  wire tx_wr_ok = tx_wr & ~tx_full;
  wire tx_rd_ok = tx_rd & ~tx_empty;
  wire rx_wr_ok = rx_wr & ~rx_full & ~rx_flush;
  wire rx_rd_ok = rx_rd & ~rx_empty & ~rx_flush;

  wire ev_tx = tx_rd_ok & ~tx_wr_ok & (tx_cnt == ONE) & ~dma_en;
  wire ev_rx = rx_wr_ok & ~dma_en;
  wire ev_ur = tx_rd & tx_empty;
  wire ev_of = rx_wr & rx_full & ~rx_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      tx_hold <= 1'b0;
      rx_hold <= 1'b0;
      flg     <= '0;
    end else begin
      tx_hold <= tx_ack;
      rx_hold <= rx_ack;
      case ({tx_wr_ok, tx_rd_ok})
        2'b10:   tx_cnt <= tx_cnt + ONE;
        2'b01:   tx_cnt <= tx_cnt - ONE;
        default: tx_cnt <= tx_cnt;
      endcase
      if (rx_flush)
        rx_cnt <= '0;
      else
        case ({rx_wr_ok, rx_rd_ok})
          2'b10:   rx_cnt <= rx_cnt + ONE;
          2'b01:   rx_cnt <= rx_cnt - ONE;
          default: rx_cnt <= rx_cnt;
        endcase
      flg <= (flg & ~flag_clr) | {ev_of, ev_ur, ev_rx, ev_tx};
    end
  end

  assign tx_req   = dma_en & tx_dma_en & ~tx_full & ~tx_hold;
  assign rx_req   = dma_en & rx_dma_en & ~rx_empty & ~rx_hold;
  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;
  assign flags    = flg;
  assign irq      = |flg;

  assert_no_req_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !tx_req && !rx_req);
  assert_tx_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> !tx_req);
  assert_rx_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |=> !rx_req);
  assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= FULL && rx_level <= FULL);
  assert_underrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd && tx_level == '0 |=> flags[2] && tx_level == '0);
  assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr && !rx_flush && rx_level == FULL && !rx_rd |=> flags[3] && rx_level == FULL);
  assert_rx_flag_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> !$past(dma_en));
  assert_tx_flag_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> !$past(dma_en));
endmodule

// File: tb/spi_dma_gate_tb.sv
module spi_dma_gate_tb;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic dma_en = 0, tx_dma_en = 0, rx_dma_en = 0, rx_flush = 0;
  logic tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0, tx_ack = 0, rx_ack = 0;
  logic [3:0] flag_clr = 0;
  logic tx_req, rx_req, irq;
  logic [3:0] tx_level, rx_level, flags;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_dma_gate u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    {dma_en, tx_dma_en, rx_dma_en, rx_flush} = 0;
    {tx_wr, tx_rd, rx_wr, rx_rd, tx_ack, rx_ack} = 0;
    flag_clr = 0;
    rst_n = 0; step(); rst_n = 1; step();
  endtask

  task automatic pulse_tx_wr(input int n);
    tx_wr = 1; repeat (n) step(); tx_wr = 0;
  endtask
  task automatic pulse_tx_rd(input int n);
    tx_rd = 1; repeat (n) step(); tx_rd = 0;
  endtask
  task automatic pulse_rx_wr(input int n);
    rx_wr = 1; repeat (n) step(); rx_wr = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("reset R5 tx_level", tx_level, 0);
    chk("reset R5 rx_level", rx_level, 0);
    chk("reset R10 flags", flags, 0);
    chk("reset R1 tx_req", tx_req, 0);

    // R1 R2 R3 R5: sweep levels and enable combinations
    for (int tl = 0; tl <= 9; tl++)
      for (int rl = 0; rl <= 9; rl++) begin
        do_reset();
        pulse_tx_wr(tl);
        pulse_rx_wr(rl);
        chk("sweep R5 tx_level", tx_level, tl > 8 ? 8 : tl);
        chk("sweep R5 rx_level", rx_level, rl > 8 ? 8 : rl);
        for (int c = 0; c < 8; c++) begin
          {dma_en, tx_dma_en, rx_dma_en} = 3'(c);
          #1;
          chk("sweep R1 R2 R3 tx_req", tx_req, int'(c[2] && c[1] && tl < 8));
          chk("sweep R1 R2 R3 rx_req", rx_req, int'(c[2] && c[0] && rl > 0));
        end
        {dma_en, tx_dma_en, rx_dma_en} = 0;
      end

    // R4: acknowledge gap, and DMA keeps FIFO full
    do_reset();
    dma_en = 1; tx_dma_en = 1; #1;
    chk("R4 tx_req before ack", tx_req, 1);
    tx_ack = 1; tx_wr = 1; step(); tx_ack = 0; tx_wr = 0;
    chk("R4 tx_req after ack", tx_req, 0);
    chk("R5 tx_level after dma write", tx_level, 1);
    step();
    chk("R4 tx_req reasserts", tx_req, 1);
    for (int i = 0; i < 40; i++) begin
      if (tx_req) begin tx_ack = 1; tx_wr = 1; end
      step(); tx_ack = 0; tx_wr = 0;
    end
    chk("R3 tx FIFO filled by dma", tx_level, 8);
    chk("R3 tx_req low when full", tx_req, 0);

    // R9 R8: drain after DMA stop, no underrun, drained flag sets when off
    dma_en = 0; #1;
    chk("R1 tx_req off", tx_req, 0);
    pulse_tx_rd(8);
    chk("R9 drained level", tx_level, 0);
    chk("R9 no underrun during drain", flags[2], 0);
    chk("R8 tx flag when dma off", flags[0], 1);

    // R4 receive side
    do_reset();
    pulse_rx_wr(2);
    dma_en = 1; rx_dma_en = 1; #1;
    chk("R3 rx_req with data", rx_req, 1);
    rx_ack = 1; rx_rd = 1; step(); rx_ack = 0; rx_rd = 0;
    chk("R4 rx_req after ack", rx_req, 0);
    chk("R5 rx_level after read", rx_level, 1);
    step();
    chk("R4 rx_req reasserts", rx_req, 1);

    // R8: ordinary flags suppressed in DMA mode; R6 underrun still reported
    do_reset();
    dma_en = 1;
    pulse_rx_wr(1);
    chk("R8 rx flag suppressed", flags[1], 0);
    pulse_tx_wr(2);
    pulse_tx_rd(2);
    chk("R8 tx flag suppressed", flags[0], 0);
    chk("R8 irq quiet", irq, 0);
    pulse_tx_rd(1);
    chk("R6 underrun in dma mode", flags[2], 1);
    chk("R6 level stays 0", tx_level, 0);
    chk("R10 irq from underrun", irq, 1);
    dma_en = 0;
    pulse_rx_wr(1);
    chk("R8 rx flag when dma off", flags[1], 1);

    // R10: individual clears
    flag_clr = 4'b0100; step(); flag_clr = 0;
    chk("R10 clear underrun only", flags, 4'b0010);
    flag_clr = 4'b0010; step(); flag_clr = 0;
    chk("R10 all clear", flags, 0);
    chk("R10 irq low", irq, 0);

    // R7: overflow with tx-only DMA, then flush
    do_reset();
    dma_en = 1; tx_dma_en = 1;
    pulse_rx_wr(8);
    chk("R7 rx full", rx_level, 8);
    chk("R7 no overflow yet", flags[3], 0);
    pulse_rx_wr(1);
    chk("R7 overflow flag", flags[3], 1);
    chk("R7 byte dropped", rx_level, 8);
    flag_clr = 4'b1000; step(); flag_clr = 0;
    rx_flush = 1; step();
    chk("R7 flush empties", rx_level, 0);
    pulse_rx_wr(12);
    chk("R7 flush discards", rx_level, 0);
    chk("R7 flush no overflow", flags[3], 0);
    rx_flush = 0;
    pulse_rx_wr(1);
    chk("R7 accepts after flush", rx_level, 1);

    // R6 with DMA off, plus simultaneous write/read
    do_reset();
    pulse_tx_rd(1);
    chk("R6 underrun dma off", flags[2], 1);
    pulse_tx_wr(3);
    tx_wr = 1; tx_rd = 1; step(); tx_wr = 0; tx_rd = 0;
    chk("R5 simultaneous keeps level", tx_level, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule